// File: doc/BRIEF.md
# DMA channel transfer engine

A single DMA channel sequencer. Software loads three registers (a 24-bit address, a 32-bit count word and a control word) and sets a start bit. The engine then moves 32-bit words through one word-wide bus master port. That port reaches both memory and a fixed device port address. Once the work is done, the engine clears its start bits and raises a one-cycle completion pulse.

The control word selects one of four modes:

- **Block mode** copies a block-size by block-count number of words in either direction between memory and the device port.
- **List mode** follows a chain of headers in memory. Each header carries an 8-bit word count and a 24-bit pointer to the next header. The words after each header go to the device.
- **Table mode** fills memory downward with a chain of back pointers that ends in a terminator word. It runs only when a second trigger bit is also set.
- **Mode 3** is reserved and finishes at once.

Arbitration between channels and interrupt generation belong to the surrounding logic.

Top module: `dma_chan_engine`

## Requirements
- R1: After a synchronous active-low reset, all three registers read 0, and bus_req and done are low.
- R2: Register select codes are 0 for address, 1 for count and 2 for control; code 3 reads 0. The address register keeps only the low 24 bits of a write. The control register stores the written value ANDed with 0x71770703. Any register write made while a transfer is in progress (from start through the done cycle) is ignored.
- R3: Control bits 10:9 select the mode: 0 table, 1 block, 2 list, 3 reserved. A transfer starts when control bit 24 is set. Table mode also needs bit 28. A table-mode control with only bit 24 set stays pending, makes no bus access and keeps its value.
- R4: Block mode takes the block size from count[15:0] and the block count from count[31:16]. A zero in either field means 65536. It moves size times count words, one read then one write per word, and the memory address starts at the address register and rises by 4 per word. When control bit 0 is 1, each word is read from memory and written to the device port (address 0xF00010 by default). When bit 0 is 0, each word is read from the device port and written to memory.
- R5: List mode reads a header at the current address. Header bits 31:24 give a word count and bits 23:0 the next header address. The count words that follow the header are read and written in order to the device port. The walk then continues at the next header, so a zero-count header only redirects. It ends once a header whose next field is 0xFFFFFF has been served.
- R6: A list transfer started with address 0xFFFFFF completes with no bus access.
- R7: Table mode takes N from count[15:0], where 0 means 65536. It writes N words at the start address and then at each lower word address in turn, stepping down by 4. Each entry holds its own address minus 4 (24-bit wrap, upper byte zero). The last entry holds 0x00FFFFFF.
- R8: Mode 3 completes with no bus access.
- R9: While bus_req is high, bus_addr, bus_we and bus_wdata hold steady until bus_ready is seen high at a clock edge. Read data is taken in that cycle.
- R10: At completion, done is high for exactly one cycle and the engine then issues no access. Control bit 24 is cleared, bit 28 is also cleared in table mode, and all other control bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for writes |
| cfg_wdata | input | 32 | Register write data |
| rd_sel | input | 2 | Register select for readback |
| rd_data | output | 32 | Readback data |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 24 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ready | input | 1 | Access accepted this cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
Four properties are checked on every cycle:
- the request hold rule on the bus;
- the single-cycle width of done and the quiet bus after it;
- the drop of control bit 24 after done;
- the lock on the address and count registers while the engine runs.

Only the bench scenarios can show that the traffic itself is right. This covers the order and values of each mode's accesses (block words in both directions, list chains with skip headers, the descending pointer table with its 65536-entry zero case) and that reserved, empty-list and untriggered table starts make no access.

// File: rtl/dma_chan_pkg.sv
// Shared types and field positions for the DMA channel engine.
// Assumes the control word layout described in the brief.
package dma_chan_pkg;

    typedef enum logic [1:0] {
        MODE_TABLE = 2'd0,
        MODE_BLOCK = 2'd1,
        MODE_LIST  = 2'd2,
        MODE_RSVD  = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BLK_RD,
        ST_BLK_WR,
        ST_LST_HDR,
        ST_LST_RD,
        ST_LST_WR,
        ST_TBL_WR,
        ST_FINISH
    } seq_state_e;

    localparam int CTL_DIR_BIT  = 0;
    localparam int CTL_MODE_LO  = 9;
    localparam int CTL_BUSY_BIT = 24;
    localparam int CTL_TRIG_BIT = 28;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

endpackage

// File: rtl/dma_chan_regs.sv
// Register file of one DMA channel: address, count and control words.
// Writes are refused while the sequencer is active; the sequencer
// clears the start bits through dedicated strobes at completion.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int              ADDR_W    = 24,
    parameter int              DATA_W    = 32,
    parameter logic [DATA_W-1:0] CTRL_MASK = 32'h7177_0703
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              lock,
    input  logic              clr_busy,
    input  logic              clr_trig,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic              ctl_dir,
    output logic [1:0]        ctl_mode,
    output logic              ctl_busy,
    output logic              ctl_trig
);

    localparam int PAD_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] ctrl_q;

    // Register storage: software writes when unlocked, start-bit clears at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (clr_busy) begin
                ctrl_q[CTL_BUSY_BIT] <= 1'b0;
            end
            if (clr_trig) begin
                ctrl_q[CTL_TRIG_BIT] <= 1'b0;
            end
            if (cfg_we && !lock) begin
                case (cfg_sel)
                    SEL_ADDR:  addr_q <= cfg_wdata[ADDR_W-1:0];
                    SEL_COUNT: cnt_q  <= cfg_wdata;
                    SEL_CTRL:  ctrl_q <= cfg_wdata & CTRL_MASK;
                    default:   ;
                endcase
            end
        end
    end

    // Readback multiplexer.
    always_comb begin
        case (rd_sel)
            SEL_ADDR:  rd_data = {{PAD_W{1'b0}}, addr_q};
            SEL_COUNT: rd_data = cnt_q;
            SEL_CTRL:  rd_data = ctrl_q;
            default:   rd_data = '0;
        endcase
    end

    assign ctl_dir  = ctrl_q[CTL_DIR_BIT];
    assign ctl_mode = ctrl_q[CTL_MODE_LO+1:CTL_MODE_LO];
    assign ctl_busy = ctrl_q[CTL_BUSY_BIT];
    assign ctl_trig = ctrl_q[CTL_TRIG_BIT];

    // R2: a write during an active transfer leaves address and count untouched
    p_locked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && lock) |=> ($stable(addr_q) && $stable(cnt_q)));

endmodule

// File: rtl/dma_chan_seq.sv
// Transfer sequencer of one DMA channel. Latches the register values at
// start, then runs block, list or table sequences over a single word bus
// with a request/ready handshake. Assumes registers are stable while it
// is active (the register file enforces this).
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter int                DATA_W   = 32,
    parameter int                CNT_W    = 16,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 24'hF0_0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_reg,
    input  logic [DATA_W-1:0] cnt_reg,
    input  logic              ctl_dir,
    input  logic [1:0]        ctl_mode,
    input  logic              ctl_busy,
    input  logic              ctl_trig,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              active,
    output logic              clr_busy,
    output logic              clr_trig,
    output logic              done
);

    localparam int                LEN_W     = CNT_W + 1;
    localparam int                HDR_W     = DATA_W - ADDR_W;
    localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] TERM_PTR  = '1;
    localparam logic [DATA_W-1:0] TERM_WORD = {{HDR_W{1'b0}}, TERM_PTR};
    localparam logic [LEN_W-1:0]  ONE_LEN   = LEN_W'(1);

    seq_state_e        st;
    xfer_mode_e        mode;
    logic              go;
    logic [ADDR_W-1:0] cur;
    logic [DATA_W-1:0] data_q;
    logic [LEN_W-1:0]  word_left;
    logic [LEN_W-1:0]  blk_left;
    logic [LEN_W-1:0]  blk_size;
    logic [HDR_W-1:0]  lst_cnt;
    logic [ADDR_W-1:0] lst_next;
    logic              dir_q;
    logic              tbl_q;
    logic [HDR_W-1:0]  hdr_cnt;
    logic [ADDR_W-1:0] hdr_ptr;

    // Expand a length field where zero stands for the full range.
    function automatic logic [LEN_W-1:0] field_len(input logic [CNT_W-1:0] f);
        return (f == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, f};
    endfunction

    assign mode    = xfer_mode_e'(ctl_mode);
    assign go      = ctl_busy && ((mode != MODE_TABLE) || ctl_trig);
    assign hdr_cnt = bus_rdata[DATA_W-1:ADDR_W];
    assign hdr_ptr = bus_rdata[ADDR_W-1:0];

    // Sequencer state, address and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cur       <= '0;
            data_q    <= '0;
            word_left <= '0;
            blk_left  <= '0;
            blk_size  <= '0;
            lst_cnt   <= '0;
            lst_next  <= '0;
            dir_q     <= 1'b0;
            tbl_q     <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (go) begin
                        cur   <= addr_reg;
                        dir_q <= ctl_dir;
                        tbl_q <= 1'b0;
                        case (mode)
                            MODE_BLOCK: begin
                                blk_size  <= field_len(cnt_reg[CNT_W-1:0]);
                                word_left <= field_len(cnt_reg[CNT_W-1:0]);
                                blk_left  <= field_len(cnt_reg[2*CNT_W-1:CNT_W]);
                                st        <= ST_BLK_RD;
                            end
                            MODE_LIST: begin
                                st <= (addr_reg == TERM_PTR) ? ST_FINISH : ST_LST_HDR;
                            end
                            MODE_TABLE: begin
                                word_left <= field_len(cnt_reg[CNT_W-1:0]);
                                tbl_q     <= 1'b1;
                                st        <= ST_TBL_WR;
                            end
                            default: st <= ST_FINISH;
                        endcase
                    end
                end
                ST_BLK_RD: begin
                    if (bus_ready) begin
                        data_q <= bus_rdata;
                        st     <= ST_BLK_WR;
                    end
                end
                ST_BLK_WR: begin
                    if (bus_ready) begin
                        cur <= cur + STEP;
                        if (word_left == ONE_LEN) begin
                            if (blk_left == ONE_LEN) begin
                                st <= ST_FINISH;
                            end else begin
                                blk_left  <= blk_left - ONE_LEN;
                                word_left <= blk_size;
                                st        <= ST_BLK_RD;
                            end
                        end else begin
                            word_left <= word_left - ONE_LEN;
                            st        <= ST_BLK_RD;
                        end
                    end
                end
                ST_LST_HDR: begin
                    if (bus_ready) begin
                        lst_cnt  <= hdr_cnt;
                        lst_next <= hdr_ptr;
                        if (hdr_cnt == '0) begin
                            if (hdr_ptr == TERM_PTR) begin
                                st <= ST_FINISH;
                            end else begin
                                cur <= hdr_ptr;
                            end
                        end else begin
                            cur <= cur + STEP;
                            st  <= ST_LST_RD;
                        end
                    end
                end
                ST_LST_RD: begin
                    if (bus_ready) begin
                        data_q <= bus_rdata;
                        st     <= ST_LST_WR;
                    end
                end
                ST_LST_WR: begin
                    if (bus_ready) begin
                        if (lst_cnt == HDR_W'(1)) begin
                            if (lst_next == TERM_PTR) begin
                                st <= ST_FINISH;
                            end else begin
                                cur <= lst_next;
                                st  <= ST_LST_HDR;
                            end
                        end else begin
                            lst_cnt <= lst_cnt - HDR_W'(1);
                            cur     <= cur + STEP;
                            st      <= ST_LST_RD;
                        end
                    end
                end
                ST_TBL_WR: begin
                    if (bus_ready) begin
                        if (word_left == ONE_LEN) begin
                            st <= ST_FINISH;
                        end else begin
                            word_left <= word_left - ONE_LEN;
                            cur       <= cur - STEP;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Bus access decode from the current state.
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = cur;
        bus_wdata = data_q;
        case (st)
            ST_BLK_RD: begin
                bus_req  = 1'b1;
                bus_addr = dir_q ? cur : DEV_ADDR;
            end
            ST_BLK_WR: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = dir_q ? DEV_ADDR : cur;
            end
            ST_LST_HDR, ST_LST_RD: begin
                bus_req = 1'b1;
            end
            ST_LST_WR: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = DEV_ADDR;
            end
            ST_TBL_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = (word_left == ONE_LEN) ? TERM_WORD
                                                   : {{HDR_W{1'b0}}, cur - STEP};
            end
            default: ;
        endcase
    end

    assign active   = (st != ST_IDLE);
    assign done     = (st == ST_FINISH);
    assign clr_busy = done;
    assign clr_trig = done && tbl_q;

    // R9: a pending access keeps its address, direction and data
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr)
                                     && $stable(bus_we) && $stable(bus_wdata)));

    // R10: completion pulse lasts one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: no access follows the completion pulse
    p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !bus_req);

endmodule

// File: rtl/dma_chan_engine.sv
// Top of one DMA channel: register file plus transfer sequencer.
// Memory and the device port share one word bus; the device port is a
// fixed address given by DEV_ADDR.
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter int                DATA_W    = 32,
    parameter int                CNT_W     = 16,
    parameter logic [DATA_W-1:0] CTRL_MASK = 32'h7177_0703,
    parameter logic [ADDR_W-1:0] DEV_ADDR  = 24'hF0_0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              done
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] cnt_q;
    logic              ctl_dir;
    logic [1:0]        ctl_mode;
    logic              ctl_busy;
    logic              ctl_trig;
    logic              active;
    logic              clr_busy;
    logic              clr_trig;

    dma_chan_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_MASK (CTRL_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .lock      (active),
        .clr_busy  (clr_busy),
        .clr_trig  (clr_trig),
        .addr_q    (addr_q),
        .cnt_q     (cnt_q),
        .ctl_dir   (ctl_dir),
        .ctl_mode  (ctl_mode),
        .ctl_busy  (ctl_busy),
        .ctl_trig  (ctl_trig)
    );

    dma_chan_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .DEV_ADDR (DEV_ADDR)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_reg  (addr_q),
        .cnt_reg   (cnt_q),
        .ctl_dir   (ctl_dir),
        .ctl_mode  (ctl_mode),
        .ctl_busy  (ctl_busy),
        .ctl_trig  (ctl_trig),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .active    (active),
        .clr_busy  (clr_busy),
        .clr_trig  (clr_trig),
        .done      (done)
    );

    // R10: the start bit is down once the completion pulse has passed
    p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !ctl_busy);

endmodule

// File: tb/dma_chan_engine_bench.sv
`timescale 1ns/1ps
module dma_chan_engine_bench;

    localparam logic [23:0] DEV = 24'hF00010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        bus_req, bus_we;
    logic [23:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ready = 1'b0;
    logic        done;

    dma_chan_engine u_dma_chan_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .done(done)
    );

    always #2.5 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    int          rdy_pct = 100;
    int          rd_cnt = 0;
    int          done_cnt = 0;
    int          hs_viol = 0;
    int          cyc = 0;
    bit          finished = 0;
    logic [31:0] dev_seq = 32'hD000_0000;
    logic [31:0] mem [4096];
    logic [23:0] wq_a[$];
    logic [31:0] wq_d[$];
    logic [23:0] ex_a[$];
    logic [31:0] ex_d[$];
    bit          hs_pend = 0;
    logic [23:0] p_addr;
    logic        p_we;
    logic [31:0] p_wdata;

    // Bus slave model: memory below 0x4000, device port at DEV.
    always @(negedge clk) begin
        if (bus_req) begin
            if (hs_pend && (bus_addr !== p_addr || bus_we !== p_we || bus_wdata !== p_wdata))
                hs_viol++;
            bus_ready = (rdy_pct >= 100) || (int'($urandom % 100) < rdy_pct);
            if (bus_ready) begin
                if (bus_we) begin
                    wq_a.push_back(bus_addr);
                    wq_d.push_back(bus_wdata);
                    if (bus_addr < 24'h4000) mem[bus_addr[13:2]] = bus_wdata;
                end else begin
                    rd_cnt++;
                    if (bus_addr == DEV) begin
                        bus_rdata = dev_seq;
                        dev_seq++;
                    end else begin
                        bus_rdata = mem[bus_addr[13:2]];
                    end
                end
            end
            hs_pend = !bus_ready;
            p_addr = bus_addr; p_we = bus_we; p_wdata = bus_wdata;
        end else begin
            if (hs_pend) hs_viol++;
            hs_pend = 0;
            bus_ready = 1'b0;
        end
        if (done) done_cnt++;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(negedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic clear_logs();
        wq_a.delete(); wq_d.delete(); ex_a.delete(); ex_d.delete();
        rd_cnt = 0; done_cnt = 0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 150000) begin
            @(negedge clk);
            n++;
        end
        check(req, "completion seen", {31'd0, done}, 32'd1);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic compare_writes(input string req);
        int mism = 0;
        check(req, "write count", wq_a.size(), ex_a.size());
        if (wq_a.size() == ex_a.size())
            foreach (ex_a[i]) if (wq_a[i] !== ex_a[i] || wq_d[i] !== ex_d[i]) mism++;
        check(req, "write stream mismatches", mism, 0);
    endtask

    // Expected traffic of a block transfer computed from the rules of R4.
    task automatic expect_block(input logic [23:0] base, input int words, input bit dir);
        for (int i = 0; i < words; i++) begin
            if (dir) begin
                ex_a.push_back(DEV);
                ex_d.push_back(mem[(base + 24'(4*i)) >> 2]);
            end else begin
                ex_a.push_back(base + 24'(4*i));
                ex_d.push_back(dev_seq + 32'(i));
            end
        end
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7321));
        for (int i = 0; i < 4096; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_reg(2'd0, v); check("R1", "address after reset", v, 32'h0);
        read_reg(2'd1, v); check("R1", "count after reset", v, 32'h0);
        read_reg(2'd2, v); check("R1", "control after reset", v, 32'h0);
        check("R1", "bus_req after reset", {31'd0, bus_req}, 32'd0);
        check("R1", "done after reset", {31'd0, done}, 32'd0);

        // R2: masking and select codes
        cfg_write(2'd0, 32'hABCD_EF12);
        read_reg(2'd0, v); check("R2", "address keeps 24 bits", v, 32'h00CD_EF12);
        cfg_write(2'd2, 32'hFEFF_FFFF);
        read_reg(2'd2, v); check("R2", "control masked", v, 32'h7077_0703);
        read_reg(2'd3, v); check("R2", "select 3 reads zero", v, 32'h0);
        cfg_write(2'd2, 32'h0);

        // R4: directed block, memory to device, 4 x 3 words
        clear_logs(); rdy_pct = 60;
        cfg_write(2'd0, 32'h100); cfg_write(2'd1, {16'd3, 16'd4});
        expect_block(24'h100, 12, 1'b1);
        cfg_write(2'd2, 32'h0100_0201);
        wait_done("R4");
        compare_writes("R4");
        check("R4", "reads in mem-to-dev block", rd_cnt, 12);
        check("R10", "done width", done_cnt, 1);
        read_reg(2'd2, v); check("R10", "control after block", v, 32'h0000_0201);

        // R4: directed block, device to memory, 5 x 2 words
        clear_logs();
        cfg_write(2'd0, 32'h400); cfg_write(2'd1, {16'd2, 16'd5});
        expect_block(24'h400, 10, 1'b0);
        cfg_write(2'd2, 32'h0100_0200);
        wait_done("R4");
        compare_writes("R4");
        check("R4", "reads in dev-to-mem block", rd_cnt, 10);

        // R4/R3: constrained random blocks with random direction and ready
        for (int t = 0; t < 6; t++) begin
            int bs = 1 + int'($urandom % 6);
            int ba = 1 + int'($urandom % 4);
            bit dir = $urandom % 2;
            logic [23:0] base = 24'h1000 + 24'(($urandom % 64) * 4);
            clear_logs(); rdy_pct = 30 + int'($urandom % 71);
            cfg_write(2'd0, {8'd0, base}); cfg_write(2'd1, {16'(ba), 16'(bs)});
            expect_block(base, bs * ba, dir);
            cfg_write(2'd2, 32'h0100_0200 | {31'd0, dir});
            wait_done("R4");
            compare_writes("R4");
            check("R3", "random block done width", done_cnt, 1);
        end

        // R2: writes during a transfer are ignored
        clear_logs(); rdy_pct = 30;
        cfg_write(2'd0, 32'h200); cfg_write(2'd1, {16'd2, 16'd8});
        expect_block(24'h200, 16, 1'b1);
        cfg_write(2'd2, 32'h0100_0201);
        repeat (4) @(negedge clk);
        cfg_write(2'd0, 32'h777); cfg_write(2'd1, 32'h1);
        wait_done("R2");
        compare_writes("R2");
        read_reg(2'd0, v); check("R2", "address unchanged by busy write", v, 32'h200);
        read_reg(2'd1, v); check("R2", "count unchanged by busy write", v, {16'd2, 16'd8});

        // R5: list walk with a zero-count redirect header
        clear_logs(); rdy_pct = 70;
        mem[24'h800 >> 2] = {8'd2, 24'h000900};
        mem[24'h804 >> 2] = 32'hA1A1_0001; mem[24'h808 >> 2] = 32'hA2A2_0002;
        mem[24'h900 >> 2] = {8'd0, 24'h000A00};
        mem[24'hA00 >> 2] = {8'd3, 24'hFFFFFF};
        mem[24'hA04 >> 2] = 32'hB1B1_0001; mem[24'hA08 >> 2] = 32'hB2B2_0002;
        mem[24'hA0C >> 2] = 32'hB3B3_0003;
        ex_a = '{DEV, DEV, DEV, DEV, DEV};
        ex_d = '{32'hA1A1_0001, 32'hA2A2_0002, 32'hB1B1_0001, 32'hB2B2_0002, 32'hB3B3_0003};
        cfg_write(2'd0, 32'h800);
        cfg_write(2'd2, 32'h0100_0401);
        wait_done("R5");
        compare_writes("R5");
        check("R5", "list reads", rd_cnt, 8);
        read_reg(2'd2, v); check("R10", "control after list", v, 32'h0000_0401);

        // R6: list starting at the terminator pointer
        clear_logs();
        cfg_write(2'd0, 32'hFF_FFFF);
        cfg_write(2'd2, 32'h0100_0400);
        wait_done("R6");
        check("R6", "accesses for empty list", rd_cnt + wq_a.size(), 0);

        // R8: reserved mode
        clear_logs();
        cfg_write(2'd0, 32'h300);
        cfg_write(2'd2, 32'h0100_0600);
        wait_done("R8");
        check("R8", "accesses for reserved mode", rd_cnt + wq_a.size(), 0);
        read_reg(2'd2, v); check("R10", "control after reserved", v, 32'h0000_0600);

        // R3: table mode without the trigger bit stays pending
        clear_logs();
        cfg_write(2'd0, 32'h300); cfg_write(2'd1, 32'd3);
        cfg_write(2'd2, 32'h0100_0000);
        repeat (30) @(negedge clk);
        check("R3", "accesses without trigger", rd_cnt + wq_a.size(), 0);
        check("R3", "no completion without trigger", done_cnt, 0);
        read_reg(2'd2, v); check("R3", "pending control kept", v, 32'h0100_0000);
        cfg_write(2'd2, 32'h0);

        // R7: small table clear
        clear_logs(); rdy_pct = 50;
        ex_a = '{24'h200, 24'h1FC, 24'h1F8, 24'h1F4, 24'h1F0};
        ex_d = '{32'h1FC, 32'h1F8, 32'h1F4, 32'h1F0, 32'h00FF_FFFF};
        cfg_write(2'd0, 32'h200); cfg_write(2'd1, 32'd5);
        cfg_write(2'd2, 32'h1100_0002);
        wait_done("R7");
        compare_writes("R7");
        check("R7", "no reads in table mode", rd_cnt, 0);
        read_reg(2'd2, v); check("R10", "control after table", v, 32'h0000_0002);

        // R7: zero count means 65536 entries
        clear_logs(); rdy_pct = 100;
        cfg_write(2'd0, 32'h03_FFFC); cfg_write(2'd1, 32'h0);
        cfg_write(2'd2, 32'h1100_0000);
        wait_done("R7");
        check("R7", "entries for zero count", wq_a.size(), 65536);
        if (wq_a.size() == 65536) begin
            int badn = 0;
            for (int i = 0; i < 65535; i++)
                if (wq_a[i] !== 24'h03FFFC - 24'(4*i) || wq_d[i] !== {8'd0, wq_a[i] - 24'd4})
                    badn++;
            check("R7", "chain entry errors", badn, 0);
            check("R7", "last entry address", {8'd0, wq_a[65535]}, 32'h0);
            check("R7", "last entry value", wq_d[65535], 32'h00FF_FFFF);
        end

        check("R9", "handshake hold violations", hs_viol, 0);
        summary();
    end

endmodule